// File: doc/BRIEF.md
# Byte Stream to Block Cipher Adapter

This block joins a byte-wide data stream to a 128-bit block cipher that has a simple start/done port. Bytes come in through a valid/ready handshake and are shifted into a 16-byte collection register. When the sixteenth byte arrives, the full block goes to the cipher as one parallel word, together with a one-cycle start pulse. The block then waits for the cipher to finish.

When the cipher raises done, the 128-bit result is loaded into an unload register. The result then leaves one byte at a time through a second valid/ready handshake, toward a consumer such as a serial transmitter. The input side stays closed from the launch of the cipher until the last result byte has been taken. After that the block is ready to gather the next block.

Top module: `byte_block_adapter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the byte counters and the state. After reset, `in_ready` is 1 and `out_valid` and `blk_start` are 0, even if a block was half collected.
- R2: A byte is accepted only on a rising edge where `in_valid` and `in_ready` are both 1. Idle cycles between bytes lose nothing. The first accepted byte becomes bits [127:120] of `blk_out`, and the sixteenth becomes bits [7:0].
- R3: In the cycle after the sixteenth byte is accepted, `blk_start` is 1 for exactly one cycle. `blk_out` holds the collected block from that cycle until the cipher result is taken.
- R4: `in_ready` is 0 from the start pulse until the last result byte has been transferred. Bytes offered in that time are not taken and do not appear in any later block.
- R5: `blk_done` is acted on only in the cycles after the start pulse while the result is still awaited. A `blk_done` seen during collection, during the start-pulse cycle or during unloading has no effect.
- R6: A `blk_done` while the result is awaited captures `blk_res`. In the next cycle `out_valid` is 1 and `out_byte` shows bits [127:120] of the result. The bytes then follow in order down to bits [7:0].
- R7: The output moves to the next byte only on a rising edge where `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_valid` stays 1 and `out_byte` does not change.
- R8: In the cycle after the sixteenth output transfer, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Incoming data byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block can accept a byte |
| blk_out | output | 128 | Collected block presented to the cipher |
| blk_start | output | 1 | One-cycle launch pulse to the cipher |
| blk_done | input | 1 | Cipher result is available |
| blk_res | input | 128 | Cipher result word |
| out_byte | output | 8 | Outgoing result byte |
| out_valid | output | 1 | Outgoing byte is valid |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
The properties assume that the cipher never returns a result in the same cycle as the start pulse. A done in that cycle is defined as ignored, so the properties treat the await phase as beginning one cycle later. They also assume that `blk_res` is valid in the cycle in which `blk_done` is high. The bench models the cipher itself. It holds done back for several cycles after the start pulse and drives `blk_res` only in the cycle in which it raises done. It also injects stray done pulses and stray input bytes on purpose, at points where the requirements say they must be ignored.

// File: rtl/bba_pkg.sv
package bba_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_LAUNCH  = 2'd1,
    ST_AWAIT   = 2'd2,
    ST_DRAIN   = 2'd3
  } bba_state_e;
endpackage

// File: rtl/bba_gather.sv
module bba_gather #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          take_i,
  input  logic [BYTE_W-1:0]             byte_i,
  output logic [BYTE_W*NUM_BYTES-1:0]   block_o,
  output logic                          fill_o
);
  localparam int BLK_W = BYTE_W * NUM_BYTES;
  localparam int CNT_W = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);

  // Older bytes move toward the top; the newest enters at the bottom.
  function automatic logic [BLK_W-1:0] push_low(input logic [BLK_W-1:0] b,
                                                input logic [BYTE_W-1:0] y);
    return {b[BLK_W-BYTE_W-1:0], y};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] sh_q;

  assign fill_o  = take_i && (cnt_q == LAST);
  assign block_o = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (take_i) begin
      sh_q  <= push_low(sh_q, byte_i);
      cnt_q <= fill_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bba_drain.sv
module bba_drain #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_i,
  input  logic [BYTE_W*NUM_BYTES-1:0]   res_i,
  input  logic                          adv_i,
  output logic [BYTE_W-1:0]             byte_o,
  output logic                          last_o
);
  localparam int BLK_W = BYTE_W * NUM_BYTES;
  localparam int CNT_W = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);

  function automatic logic [BYTE_W-1:0] top_byte(input logic [BLK_W-1:0] b);
    return b[BLK_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BLK_W-1:0] pop_high(input logic [BLK_W-1:0] b);
    return {b[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] sh_q;

  assign byte_o = top_byte(sh_q);
  assign last_o = adv_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      sh_q  <= res_i;
    end else if (adv_i) begin
      sh_q  <= pop_high(sh_q);
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bba_ctrl.sv
module bba_ctrl
  import bba_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fill_i,
  input  logic done_i,
  input  logic last_i,
  output logic in_ready_o,
  output logic start_o,
  output logic wait_o,
  output logic out_valid_o
);
  bba_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_COLLECT: if (fill_i) st_d = ST_LAUNCH;
      ST_LAUNCH:              st_d = ST_AWAIT;
      ST_AWAIT:   if (done_i) st_d = ST_DRAIN;
      ST_DRAIN:   if (last_i) st_d = ST_COLLECT;
      default:                st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_COLLECT;
    else     st_q <= st_d;
  end

  assign in_ready_o  = (st_q == ST_COLLECT);
  assign start_o     = (st_q == ST_LAUNCH);
  assign wait_o      = (st_q == ST_AWAIT);
  assign out_valid_o = (st_q == ST_DRAIN);
endmodule

// File: rtl/byte_block_adapter.sv
module byte_block_adapter #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [BYTE_W-1:0]           in_byte,
  input  logic                        in_valid,
  output logic                        in_ready,
  output logic [BYTE_W*NUM_BYTES-1:0] blk_out,
  output logic                        blk_start,
  input  logic                        blk_done,
  input  logic [BYTE_W*NUM_BYTES-1:0] blk_res,
  output logic [BYTE_W-1:0]           out_byte,
  output logic                        out_valid,
  input  logic                        out_ready
);
  // Named internal events, also observed by the bound checker.
  logic accept_evt;
  logic fill_evt;
  logic wait_phase;
  logic load_evt;
  logic xfer_evt;
  logic last_evt;

  assign accept_evt = in_valid && in_ready;
  assign load_evt   = wait_phase && blk_done;
  assign xfer_evt   = out_valid && out_ready;

  bba_gather #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) gather_i (
    .clk(clk), .rst(rst), .take_i(accept_evt), .byte_i(in_byte),
    .block_o(blk_out), .fill_o(fill_evt)
  );

  bba_ctrl ctrl_i (
    .clk(clk), .rst(rst), .fill_i(fill_evt), .done_i(blk_done),
    .last_i(last_evt), .in_ready_o(in_ready), .start_o(blk_start),
    .wait_o(wait_phase), .out_valid_o(out_valid)
  );

  bba_drain #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) drain_i (
    .clk(clk), .rst(rst), .load_i(load_evt), .res_i(blk_res),
    .adv_i(xfer_evt), .byte_o(out_byte), .last_o(last_evt)
  );
endmodule

// File: rtl/byte_block_adapter_checker.sv
module byte_block_adapter_checker #(
  parameter int BYTE_W = 8,
  parameter int BLK_W  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_byte,
  input logic              blk_start,
  input logic [BLK_W-1:0]  blk_out,
  input logic              blk_done,
  input logic              fill_evt,
  input logic              wait_phase,
  input logic              last_evt
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid && !blk_start));

  assert_start_after_fill_R3: assert property (@(posedge clk) disable iff (rst)
    fill_evt |=> blk_start);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> !blk_start);

  assert_block_hold_R3: assert property (@(posedge clk) disable iff (rst)
    wait_phase |=> $stable(blk_out));

  assert_input_closed_R4: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !(out_valid || blk_start || wait_phase));

  assert_done_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (blk_done && !wait_phase && !out_valid) |=> !out_valid);

  assert_result_opens_R6: assert property (@(posedge clk) disable iff (rst)
    (wait_phase && blk_done) |=> out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_return_R8: assert property (@(posedge clk) disable iff (rst)
    last_evt |=> (in_ready && !out_valid));
endmodule

bind byte_block_adapter byte_block_adapter_checker #(
  .BYTE_W(BYTE_W), .BLK_W(BYTE_W*NUM_BYTES)
) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .blk_start(blk_start),
  .blk_out(blk_out), .blk_done(blk_done), .fill_evt(fill_evt),
  .wait_phase(wait_phase), .last_evt(last_evt)
);

// File: tb/byte_block_adapter_tb.sv
module byte_block_adapter_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   in_byte = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] blk_out;
  logic         blk_start;
  logic         blk_done = 1'b0;
  logic [127:0] blk_res = '0;
  logic [7:0]   out_byte;
  logic         out_valid;
  logic         out_ready = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  byte_block_adapter dut_i (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .blk_out(blk_out), .blk_start(blk_start),
    .blk_done(blk_done), .blk_res(blk_res), .out_byte(out_byte),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  // Stimulus table: block fed in, and the result the modelled cipher returns.
  localparam logic [127:0] VEC_IN [4] = '{
    128'h00112233_44556677_8899AABB_CCDDEEFF,
    128'hFFFFFFFF_00000000_A5A5A5A5_5A5A5A5A,
    128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
    128'h80000000_00000000_00000000_00000001
  };
  localparam logic [127:0] VEC_RES [4] = '{
    128'h69C4E0D8_6A7B0430_D8CDB780_70B4C55A,
    128'h01020304_05060708_090A0B0C_0D0E0F10,
    128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0,
    128'h00000000_00000000_00000000_000000FF
  };

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_block(input logic [127:0] din, input logic [127:0] dres,
                           input bit gaps, input bit stalls, input bit early_done);
    for (int i = 0; i < 16; i++) begin
      if (gaps && (i % 4 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      chk(in_ready, "R2 ready while collecting", {127'd0, in_ready}, 128'd1);
      in_valid = 1'b1;
      in_byte  = din[127 - 8*i -: 8];
      @(negedge clk);
    end
    // Start-pulse cycle: offer a stray byte, and optionally an early done.
    in_valid = 1'b1;
    in_byte  = 8'hEE;
    chk(blk_start, "R3 start pulse", {127'd0, blk_start}, 128'd1);
    chk(blk_out == din, "R2 block order", blk_out, din);
    chk(!in_ready, "R4 input closed", {127'd0, in_ready}, 128'd0);
    if (early_done) begin
      blk_done = 1'b1;
      blk_res  = ~dres;
    end
    @(negedge clk);
    blk_done = 1'b0;
    chk(!blk_start, "R3 single pulse", {127'd0, blk_start}, 128'd0);
    chk(!out_valid, "R5 done during start ignored", {127'd0, out_valid}, 128'd0);
    repeat (2) @(negedge clk);
    chk(blk_out == din, "R3 block held / R4 stray byte ignored", blk_out, din);
    chk(!out_valid, "R5 still awaiting", {127'd0, out_valid}, 128'd0);
    in_valid = 1'b0;
    blk_done = 1'b1;
    blk_res  = dres;
    @(negedge clk);
    blk_done = 1'b0;
    blk_res  = '0;
    for (int j = 0; j < 16; j++) begin
      if (stalls && (j % 3 == 0)) begin
        out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid && out_byte == dres[127 - 8*j -: 8], "R7 stall holds byte",
            {120'd0, out_byte}, {120'd0, dres[127 - 8*j -: 8]});
        // A done during unloading must not reload the result.
        blk_done = 1'b1;
        blk_res  = ~dres;
        @(negedge clk);
        blk_done = 1'b0;
        chk(out_byte == dres[127 - 8*j -: 8], "R5 done during unload ignored",
            {120'd0, out_byte}, {120'd0, dres[127 - 8*j -: 8]});
      end
      out_ready = 1'b1;
      chk(out_valid && out_byte == dres[127 - 8*j -: 8],
          (j == 0) ? "R6 first result byte" : "R7 result byte order",
          {119'd0, out_valid, out_byte}, {119'd0, 1'b1, dres[127 - 8*j -: 8]});
      chk(!in_ready, "R4 input closed while unloading", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R8 return to collect",
        {126'd0, out_valid, in_ready}, 128'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(in_ready && !out_valid && !blk_start, "R1 reset state",
        {125'd0, in_ready, out_valid, blk_start}, 128'd4);

    for (int v = 0; v < 4; v++)
      run_block(VEC_IN[v], VEC_RES[v], v[0], v[1], v == 2);

    // R5: done while collecting has no effect.
    blk_done = 1'b1;
    blk_res  = VEC_RES[0];
    @(negedge clk);
    blk_done = 1'b0;
    chk(!out_valid && in_ready, "R5 done during collect ignored",
        {126'd0, out_valid, in_ready}, 128'd1);

    // R1: reset in the middle of a block clears the byte count.
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1;
      in_byte  = 8'h77;
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready && !out_valid && !blk_start, "R1 reset mid block",
        {125'd0, in_ready, out_valid, blk_start}, 128'd4);
    run_block(VEC_IN[3], VEC_RES[1], 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule